// File: doc/BRIEF.md
# Multi-Level Cell Reprogram Safety Checker

This block is a cycle-level model of one two-bit flash storage cell, where the low bit and the high bit share one threshold level. It follows the cell through five internal states rather than the four visible bit patterns. Two states both read low 0 and high 1, and they behave differently on later programming: one is reached by clearing the low bit from erased, and the other is the top threshold level.

Each cycle the block accepts at most one bit-program request. The request names the low or the high bit and gives the value 0 (clear) or 1 (leave alone). The block updates the modelled cell and reports whether the operation was safe. If it was not, the fault code says whether the requested clear failed to take effect or whether a bit was disturbed. An erase strobe returns the cell to the erased pattern. Firmware-side tooling or a controller model can drive a page's worth of these cells to find out which reprogram sequences are allowed before the next erase.

Top module: `mlc_reprog_checker`

## Requirements
- R1: Reset, or an erase strobe sampled at a clock edge, leaves low=1, high=1, fault 00 and safe=1 after that edge, from any state. Erase wins over a program request in the same cycle.
- R2: A low-bit clear from the erased state gives low=0, high=1 with fault 00. Repeating the low clear before the high bit has been programmed keeps that pattern and stays safe.
- R3: A high-bit clear from the erased state gives low=1, high=0 with fault 00.
- R4: A request with value 1, on either bit and in any state, leaves both bits unchanged and reports fault 00.
- R5: A low-bit clear while the cell reads low=1, high=0 leaves the low bit at 1 and reports fault 01 (ineffective).
- R6: A second high-bit clear while the cell reads low=1, high=0 disturbs the low bit to 0, giving low=0, high=0, and reports fault 10 (disturbance).
- R7: A high-bit clear while the cell reads low=0, high=0 moves it to the top level, which reads low=0, high=1, and reports fault 10.
- R8: At the top level a high-bit clear leaves the high bit at 1 with fault 01, and a low-bit clear is safe with no change. A low-bit clear at low=0, high=0 is also safe with no change.
- R9: The fault code is 2 bits: 00 safe, 01 ineffective, 10 disturbance. safe is 1 exactly when the code is 00. A cycle with no request and no erase reports 00.
- R10: A high-bit clear from the low-cleared state (reached by a low clear from erased) is safe and gives low=0, high=0. A high-bit clear from the top level, which reads the same pattern, is not safe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase_i | input | 1 | Erase strobe |
| prog_i | input | 1 | Program request valid |
| prog_hi_i | input | 1 | 1 selects the high bit, 0 the low bit |
| prog_val_i | input | 1 | Requested bit value (0 clears) |
| low_bit_o | output | 1 | Current low bit read value |
| high_bit_o | output | 1 | Current high bit read value |
| safe_o | output | 1 | Last operation was safe |
| fault_o | output | 2 | Fault code of the last operation |

## Verification
Every result is due one clock edge after the inputs that caused it. The bits, the safe flag and the fault code all change at the edge that samples the request or the erase, and they hold until the next edge. The bench drives inputs on the falling edge. It advances its behavioural level model at the rising edge and compares all four outputs a short time after that edge, so each comparison pairs one operation with its own result. Directed sequences reach every one of the five states and apply every request kind there. Long random runs with erase mixed in then check the same one-edge latency under back-to-back traffic.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

  localparam int FAULT_W = 2;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_ERASED = 3'd0,  // reads low 1, high 1
    ST_LO     = 3'd1,  // low cleared first, reads 0,1
    ST_HI     = 3'd2,  // reads 1,0
    ST_BOTH   = 3'd3,  // reads 0,0
    ST_TOP    = 3'd4   // top level, reads 0,1
  } cell_st_t;

  typedef enum logic [FAULT_W-1:0] {
    FLT_NONE  = 2'b00,
    FLT_INEFF = 2'b01,
    FLT_DIST  = 2'b10
  } fault_t;

  typedef struct packed {
    cell_st_t nxt;
    fault_t   flt;
  } step_t;

  // One program request applied to a state; a value of 1 never moves the cell.
  function automatic step_t cell_step(cell_st_t s, logic hi, logic val);
    step_t r;
    r.nxt = s;
    r.flt = FLT_NONE;
    if (!val) begin
      case (s)
        ST_ERASED: r.nxt = hi ? ST_HI : ST_LO;
        ST_LO:     r.nxt = hi ? ST_BOTH : ST_LO;
        ST_HI: begin
          if (hi) begin
            r.nxt = ST_BOTH;
            r.flt = FLT_DIST;
          end else begin
            r.flt = FLT_INEFF;
          end
        end
        ST_BOTH: begin
          if (hi) begin
            r.nxt = ST_TOP;
            r.flt = FLT_DIST;
          end
        end
        ST_TOP: begin
          if (hi) r.flt = FLT_INEFF;
        end
        default: r.nxt = ST_ERASED;
      endcase
    end
    return r;
  endfunction

  // Read value of a state as {low, high}.
  function automatic logic [1:0] cell_bits(cell_st_t s);
    case (s)
      ST_ERASED: return 2'b11;
      ST_LO:     return 2'b01;
      ST_HI:     return 2'b10;
      ST_BOTH:   return 2'b00;
      ST_TOP:    return 2'b01;
      default:   return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/mlc_step_logic.sv
module mlc_step_logic
  import mlc_pkg::*;
(
  input  cell_st_t st_i,
  input  logic     erase_i,
  input  logic     req_i,
  input  logic     hi_i,
  input  logic     val_i,
  output cell_st_t nxt_o,
  output fault_t   flt_o,
  output logic     dist_evt_o,
  output logic     ineff_evt_o
);

  step_t r;

  always_comb begin
    r     = cell_step(st_i, hi_i, val_i);
    nxt_o = st_i;
    flt_o = FLT_NONE;
    if (erase_i) begin
      nxt_o = ST_ERASED;
    end else if (req_i) begin
      nxt_o = r.nxt;
      flt_o = r.flt;
    end
  end

  assign dist_evt_o  = (flt_o == FLT_DIST);
  assign ineff_evt_o = (flt_o == FLT_INEFF);

endmodule

// File: rtl/mlc_cell_reg.sv
module mlc_cell_reg
  import mlc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cell_st_t nxt_i,
  input  fault_t   flt_i,
  output cell_st_t st_o,
  output fault_t   flt_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_o  <= ST_ERASED;
      flt_o <= FLT_NONE;
    end else begin
      st_o  <= nxt_i;
      flt_o <= flt_i;
    end
  end

  // R9: only three fault codes exist
  p_fault_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flt_o != 2'b11);

  // R1: the register never holds an undefined state
  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_o inside {ST_ERASED, ST_LO, ST_HI, ST_BOTH, ST_TOP});

endmodule

// File: rtl/mlc_bit_decode.sv
module mlc_bit_decode
  import mlc_pkg::*;
(
  input  cell_st_t st_i,
  input  fault_t   flt_i,
  output logic     low_o,
  output logic     high_o,
  output logic     safe_o
);

  logic [1:0] bits;

  assign bits   = cell_bits(st_i);
  assign low_o  = bits[1];
  assign high_o = bits[0];
  assign safe_o = (flt_i == FLT_NONE);

endmodule

// File: rtl/mlc_reprog_checker.sv
module mlc_reprog_checker
  import mlc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               erase_i,
  input  logic               prog_i,
  input  logic               prog_hi_i,
  input  logic               prog_val_i,
  output logic               low_bit_o,
  output logic               high_bit_o,
  output logic               safe_o,
  output logic [FAULT_W-1:0] fault_o
);

  cell_st_t st_q;
  cell_st_t st_d;
  fault_t   flt_d;
  fault_t   flt_q;
  logic     dist_evt;
  logic     ineff_evt;

  mlc_step_logic u_step (
    .st_i       (st_q),
    .erase_i    (erase_i),
    .req_i      (prog_i),
    .hi_i       (prog_hi_i),
    .val_i      (prog_val_i),
    .nxt_o      (st_d),
    .flt_o      (flt_d),
    .dist_evt_o (dist_evt),
    .ineff_evt_o(ineff_evt)
  );

  mlc_cell_reg u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .nxt_i(st_d),
    .flt_i(flt_d),
    .st_o (st_q),
    .flt_o(flt_q)
  );

  mlc_bit_decode u_dec (
    .st_i  (st_q),
    .flt_i (flt_q),
    .low_o (low_bit_o),
    .high_o(high_bit_o),
    .safe_o(safe_o)
  );

  assign fault_o = flt_q;

  // R1: erase leaves the erased pattern one edge later
  p_erase_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> (low_bit_o && high_bit_o && fault_o == 2'b00));

  // R4: value 1 requests change nothing and are safe
  p_one_is_noop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase_i && prog_i && prog_val_i) |=>
      ($stable({low_bit_o, high_bit_o}) && fault_o == 2'b00));

  // R5: an ineffective clear leaves the read value as it was
  p_ineff_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ineff_evt |=> $stable({low_bit_o, high_bit_o}));

  // R6: the low bit can only return to 1 through erase
  p_low_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_bit_o) |-> $past(erase_i));

  // R7: the high bit returns to 1 only through erase or a disturbance
  p_high_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(high_bit_o) |-> ($past(erase_i) || $past(dist_evt)));

  // R9: safe and a nonzero code never appear together
  p_safe_vs_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(safe_o && fault_o != 2'b00));

endmodule

// File: tb/mlc_reprog_checker_bench.sv
module mlc_reprog_checker_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       erase_i = 1'b0;
  logic       prog_i = 1'b0;
  logic       prog_hi_i = 1'b0;
  logic       prog_val_i = 1'b0;
  logic       low_bit_o;
  logic       high_bit_o;
  logic       safe_o;
  logic [1:0] fault_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // level model: 0 erased, 1 low-only, 2 high-only, 3 both, 4 top
  int m_lvl = 0;
  int m_flt = 0;
  string m_tag = "R1";

  always #4 clk = ~clk;  // 125 MHz

  mlc_reprog_checker u_mlc_reprog_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase_i   (erase_i),
    .prog_i    (prog_i),
    .prog_hi_i (prog_hi_i),
    .prog_val_i(prog_val_i),
    .low_bit_o (low_bit_o),
    .high_bit_o(high_bit_o),
    .safe_o    (safe_o),
    .fault_o   (fault_o)
  );

  function automatic bit exp_low(int l);
    return (l == 0) || (l == 2);
  endfunction

  function automatic bit exp_high(int l);
    return (l == 0) || (l == 1) || (l == 4);
  endfunction

  task automatic model(bit e, bit p, bit h, bit v);
    m_flt = 0;
    if (e) begin
      m_lvl = 0; m_tag = "R1";
    end else if (!p) begin
      m_tag = "R9";
    end else if (v) begin
      m_tag = "R4";
    end else if (!h) begin
      if (m_lvl == 0 || m_lvl == 1) begin m_lvl = 1; m_tag = "R2"; end
      else if (m_lvl == 2) begin m_flt = 1; m_tag = "R5"; end
      else m_tag = "R8";
    end else begin
      case (m_lvl)
        0: begin m_lvl = 2; m_tag = "R3"; end
        1: begin m_lvl = 3; m_tag = "R10"; end
        2: begin m_lvl = 3; m_flt = 2; m_tag = "R6"; end
        3: begin m_lvl = 4; m_flt = 2; m_tag = "R7"; end
        default: begin m_flt = 1; m_tag = "R8"; end
      endcase
    end
  endtask

  task automatic compare();
    bit el, eh, es;
    el = exp_low(m_lvl);
    eh = exp_high(m_lvl);
    es = (m_flt == 0);
    vectors++;
    if (low_bit_o !== el || high_bit_o !== eh || safe_o !== es || fault_o !== m_flt[1:0]) begin
      miscompares++;
      $display("FAIL %s: got lo=%0d hi=%0d safe=%0d fault=%0d, expected lo=%0d hi=%0d safe=%0d fault=%0d",
               m_tag, low_bit_o, high_bit_o, safe_o, fault_o, el, eh, es, m_flt);
    end
  endtask

  task automatic op(bit e, bit p, bit h, bit v);
    @(negedge clk);
    erase_i = e; prog_i = p; prog_hi_i = h; prog_val_i = v;
    @(posedge clk);
    model(e, p, h, v);
    #2;
    compare();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    m_tag = "R1";
    compare();  // R1 reset state
    @(negedge clk);
    rst_n = 1'b1;

    // R2 repeated low clears, R10 then first high clear safe, R7 second
    op(0, 1, 0, 0); op(0, 1, 0, 0); op(0, 1, 0, 0);
    op(0, 1, 1, 0);
    op(0, 0, 0, 0);      // R9 idle
    op(0, 1, 0, 0);      // R8 low clear at 0,0
    op(0, 1, 1, 0);      // R7
    op(0, 1, 1, 0);      // R8 high ineffective at top, R10 contrast
    op(0, 1, 0, 0);      // R8 low safe at top
    op(0, 1, 1, 1); op(0, 1, 0, 1);  // R4
    op(1, 1, 1, 0);      // R1 erase wins
    // R3, R5, R4 at high-only, R6
    op(0, 1, 1, 0);
    op(0, 1, 0, 0);
    op(0, 1, 0, 1);
    op(0, 1, 1, 1);
    op(0, 1, 1, 0);
    op(0, 1, 1, 0);
    op(1, 0, 0, 0);
    op(0, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      op(r == 0, r > 2, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule